// File: doc/BRIEF.md
# Dual-Host Serial Register Bank

This block holds a bank of 64 registers, each 24 bits wide, shared by two host processors. Each host reaches the bank through its own serial slave port. A port has a serial clock, a data input, a data output, a select line that is active high, and an interrupt line to its host. The two ports run independently of each other. Their inputs are brought into one system clock through synchronizers. Every register update happens in that system clock domain, so writes that collide are settled there.

A transfer is one 32-bit frame, sent most significant bit first and sampled on rising serial clock edges. The frame order is:

1. a direction bit, where 1 means write;
2. a 6-bit register index;
3. one spacer bit that carries no meaning;
4. 24 data bits.

A write takes effect only when exactly 32 bits have arrived before select goes low. For a read, the port captures the addressed register when the spacer bit arrives. It then presents the 24 bits on its data output, one bit per serial clock, during the data phase.

Index 0 is an interrupt status register. An event input sets its bits, and a host clears a bit by writing a 1 to it. Index 1 holds the interrupt mask for the first port and index 2 the mask for the second. Each interrupt output is raised while any status bit is set under that port's mask.

Top module: `dual_spi_regbank`

## Requirements
- R1: After reset, the status register (index 0) and both mask registers (indices 1 and 2) read as zero, and both data outputs and both interrupt outputs are low.
- R2: A write frame of exactly 32 bits, with the direction bit (the first bit) at 1, followed by the index, then the spacer bit, then 24 data bits MSB first, stores those data bits in the indexed register.
- R3: In a read frame (direction bit 0), the data output carries the indexed register MSB first. The value is sampled before each rising serial clock edge of bits 9 to 32. The output is low before each of the first 8 rising edges, and low for the whole of a write frame.
- R4: A write frame that ends with fewer than 32 bits or more than 32 bits leaves the indexed register unchanged.
- R5: Both ports reach the same register array, so a value written through one port reads back through the other.
- R6: When both ports commit writes in the same system cycle, the first port's value is kept if the indices match. If the indices differ, both writes take effect.
- R7: A bit of the event input that is high for one system cycle sets the matching bit of register 0. Writing register 0 clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R8: The first port's interrupt is high exactly when register 0 ANDed with register 1 is non-zero. The second port's interrupt is high exactly when register 0 ANDed with register 2 is non-zero. Each follows one system cycle after the registers change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_set | input | 24 | Pulses that set bits of the status register |
| a_sclk | input | 1 | First port serial clock |
| a_sel | input | 1 | First port select, active high |
| a_mosi | input | 1 | First port serial data in |
| a_miso | output | 1 | First port serial data out |
| a_irq | output | 1 | First port interrupt |
| b_sclk | input | 1 | Second port serial clock |
| b_sel | input | 1 | Second port select, active high |
| b_mosi | input | 1 | Second port serial data in |
| b_miso | output | 1 | Second port serial data out |
| b_irq | output | 1 | Second port interrupt |

## Verification
The hardest case to reach from the pins is two commits landing in the same system cycle. The two hosts are asynchronous, so such commits almost never line up by chance. The bench forces the case by driving both ports in lockstep, with the same edge times and the same select release. Both frames then cross equal synchronizer depths and commit together. This runs once with a shared index and once with different indices, and each register is read back afterwards.

// File: rtl/dspi_pkg.sv
package dspi_pkg;
  localparam int NPORTS    = 2;
  localparam int STAT_IDX  = 0;
  localparam int MASKA_IDX = 1;
  localparam int MASKB_IDX = 2;

  function automatic int frame_bits(input int aw, input int dw);
    return aw + dw + 2;
  endfunction
endpackage

// File: rtl/dspi_sync.sv
module dspi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk) begin
    if (rst) ff <= '0;
    else     ff <= {ff[STAGES-2:0], d_i};
  end

  assign q_o = ff[STAGES-1];
endmodule

// File: rtl/dspi_port.sv
module dspi_port #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              sel_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int FRAME_W = dspi_pkg::frame_bits(ADDR_W, DATA_W);
  localparam int HDR_W   = ADDR_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W - 1);

  logic [2:0] raw, syn;
  logic       sclk_s, sel_s, mosi_s;
  logic       sclk_d, sel_d;
  logic       rise, sel_rise, sel_fall;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] shreg;
  logic [DATA_W-1:0]  tx_q;
  logic               tx_act;
  logic               miso_q;

  assign raw = {mosi_i, sel_i, sclk_i};

  for (genvar g = 0; g < 3; g++) begin : g_sync
    dspi_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst(rst), .d_i(raw[g]), .q_o(syn[g])
    );
  end

  assign sclk_s   = syn[0];
  assign sel_s    = syn[1];
  assign mosi_s   = syn[2];
  assign rise     = sclk_s & ~sclk_d & sel_s;
  assign sel_rise = sel_s & ~sel_d;
  assign sel_fall = sel_d & ~sel_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d     <= 1'b0;
      sel_d      <= 1'b0;
      cnt        <= '0;
      shreg      <= '0;
      tx_q       <= '0;
      tx_act     <= 1'b0;
      miso_q     <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      sclk_d <= sclk_s;
      sel_d  <= sel_s;

      if (sel_rise)                    cnt <= '0;
      else if (rise && cnt != CNT_MAX) cnt <= cnt + 1'b1;

      if (rise) shreg <= {shreg[FRAME_W-2:0], mosi_s};

      if (sel_rise || sel_fall) begin
        tx_q   <= '0;
        tx_act <= 1'b0;
      end else if (rise && cnt == CNT_HDR) begin
        tx_q   <= rd_data_i;
        tx_act <= ~shreg[ADDR_W];
      end else if (rise) begin
        tx_q <= {tx_q[DATA_W-2:0], 1'b0};
      end

      miso_q     <= tx_act & tx_q[DATA_W-1];
      wr_valid_o <= sel_fall && (cnt == CNT_FULL) && shreg[FRAME_W-1];
      if (sel_fall) begin
        wr_addr_o <= shreg[FRAME_W-2 -: ADDR_W];
        wr_data_o <= shreg[DATA_W-1:0];
      end
    end
  end

  assign rd_addr_o = shreg[ADDR_W-1:0];
  assign miso_o    = miso_q;

  assert_commit_on_release_R4: assert property (@(posedge clk) disable iff (rst)
    wr_valid_o |-> ($past(sel_d) && !$past(sel_s)));

  assert_miso_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(sel_s) |-> ##2 !miso_o);
endmodule

// File: rtl/dspi_regs.sv
module dspi_regs #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] evt_set,
  input  logic              wa_valid,
  input  logic [ADDR_W-1:0] wa_addr,
  input  logic [DATA_W-1:0] wa_data,
  input  logic              wb_valid,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [DATA_W-1:0] wb_data,
  input  logic [ADDR_W-1:0] ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [ADDR_W-1:0] rb_addr,
  output logic [DATA_W-1:0] rb_data,
  output logic              irq_a_o,
  output logic              irq_b_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(dspi_pkg::STAT_IDX);
  localparam logic [ADDR_W-1:0] A_MASKA = ADDR_W'(dspi_pkg::MASKA_IDX);
  localparam logic [ADDR_W-1:0] A_MASKB = ADDR_W'(dspi_pkg::MASKB_IDX);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] mem_qa, mem_qb;
  logic [ADDR_W-1:0] ra_addr_q, rb_addr_q;
  logic [DATA_W-1:0] status_q, mask_a_q, mask_b_q;
  logic              pend_v;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] clr_bits;
  logic              irq_a_q, irq_b_q;

  // Priority: first port, then a deferred second-port write, then second port.
  always_comb begin
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    if (wa_valid) begin
      wr_en = 1'b1; wr_addr = wa_addr; wr_data = wa_data;
    end else if (pend_v) begin
      wr_en = 1'b1; wr_addr = pend_addr; wr_data = pend_data;
    end else if (wb_valid) begin
      wr_en = 1'b1; wr_addr = wb_addr; wr_data = wb_data;
    end
  end

  assign clr_bits = (wr_en && wr_addr == A_STAT) ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    mem_qa <= mem[ra_addr];
    mem_qb <= mem[rb_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v    <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
      status_q  <= '0;
      mask_a_q  <= '0;
      mask_b_q  <= '0;
      ra_addr_q <= '0;
      rb_addr_q <= '0;
      irq_a_q   <= 1'b0;
      irq_b_q   <= 1'b0;
    end else begin
      pend_v    <= wa_valid && wb_valid && (wa_addr != wb_addr);
      pend_addr <= wb_addr;
      pend_data <= wb_data;
      status_q  <= (status_q & ~clr_bits) | evt_set;
      if (wr_en && wr_addr == A_MASKA) mask_a_q <= wr_data;
      if (wr_en && wr_addr == A_MASKB) mask_b_q <= wr_data;
      ra_addr_q <= ra_addr;
      rb_addr_q <= rb_addr;
      irq_a_q   <= |(status_q & mask_a_q);
      irq_b_q   <= |(status_q & mask_b_q);
    end
  end

  function automatic logic [DATA_W-1:0] pick(input logic [ADDR_W-1:0] a,
                                             input logic [DATA_W-1:0] m);
    if (a == A_STAT)       return status_q;
    else if (a == A_MASKA) return mask_a_q;
    else if (a == A_MASKB) return mask_b_q;
    else                   return m;
  endfunction

  assign ra_data = pick(ra_addr_q, mem_qa);
  assign rb_data = pick(rb_addr_q, mem_qb);
  assign irq_a_o = irq_a_q;
  assign irq_b_o = irq_b_q;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (status_q == '0 && mask_a_q == '0 && mask_b_q == '0 && !irq_a_o && !irq_b_o));

  assert_same_index_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (wa_valid && wb_valid && wa_addr == wb_addr) |=> !pend_v);

  assert_status_set_by_event_R7: assert property (@(posedge clk) disable iff (rst)
    ((status_q & ~$past(status_q) & ~$past(evt_set)) == '0));

  assert_irq_a_follows_R8: assert property (@(posedge clk) disable iff (rst)
    (|(status_q & mask_a_q)) |=> irq_a_o);

  assert_irq_b_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !(|(status_q & mask_b_q)) |=> !irq_b_o);
endmodule

// File: rtl/dual_spi_regbank.sv
module dual_spi_regbank #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] evt_set,
  input  logic              a_sclk,
  input  logic              a_sel,
  input  logic              a_mosi,
  output logic              a_miso,
  output logic              a_irq,
  input  logic              b_sclk,
  input  logic              b_sel,
  input  logic              b_mosi,
  output logic              b_miso,
  output logic              b_irq
);
  localparam int NP = dspi_pkg::NPORTS;

  logic [NP-1:0]     sclk_v, sel_v, mosi_v, miso_v, wv_v;
  logic [ADDR_W-1:0] wa_v [NP];
  logic [ADDR_W-1:0] ra_v [NP];
  logic [DATA_W-1:0] wd_v [NP];
  logic [DATA_W-1:0] rd_v [NP];

  assign sclk_v = {b_sclk, a_sclk};
  assign sel_v  = {b_sel, a_sel};
  assign mosi_v = {b_mosi, a_mosi};
  assign a_miso = miso_v[0];
  assign b_miso = miso_v[1];

  for (genvar p = 0; p < NP; p++) begin : g_port
    dspi_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) port_i (
      .clk(clk), .rst(rst),
      .sclk_i(sclk_v[p]), .sel_i(sel_v[p]), .mosi_i(mosi_v[p]),
      .miso_o(miso_v[p]),
      .rd_addr_o(ra_v[p]), .rd_data_i(rd_v[p]),
      .wr_valid_o(wv_v[p]), .wr_addr_o(wa_v[p]), .wr_data_o(wd_v[p])
    );
  end

  dspi_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst(rst), .evt_set(evt_set),
    .wa_valid(wv_v[0]), .wa_addr(wa_v[0]), .wa_data(wd_v[0]),
    .wb_valid(wv_v[1]), .wb_addr(wa_v[1]), .wb_data(wd_v[1]),
    .ra_addr(ra_v[0]), .ra_data(rd_v[0]),
    .rb_addr(ra_v[1]), .rb_data(rd_v[1]),
    .irq_a_o(a_irq), .irq_b_o(b_irq)
  );
endmodule

// File: tb/dual_spi_regbank_tb_top.sv
module dual_spi_regbank_tb_top;
  localparam int CLK_P = 10;
  localparam int HALF  = 8;
  localparam int WDOG  = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [23:0] evt_set = '0;
  logic a_sclk = 0, a_sel = 0, a_mosi = 0, b_sclk = 0, b_sel = 0, b_mosi = 0;
  logic a_miso, a_irq, b_miso, b_irq;
  int   n_run = 0, n_fail = 0;
  bit   done = 0;

  always #(CLK_P/2) clk = ~clk;

  dual_spi_regbank dut_i (
    .clk(clk), .rst(rst), .evt_set(evt_set),
    .a_sclk(a_sclk), .a_sel(a_sel), .a_mosi(a_mosi), .a_miso(a_miso), .a_irq(a_irq),
    .b_sclk(b_sclk), .b_sel(b_sel), .b_mosi(b_mosi), .b_miso(b_miso), .b_irq(b_irq)
  );

  // Vector word: {port(1: 0=first,1=second), write(1), index(6), data(24)}.
  // For reads the data field is the expected value.
  localparam logic [31:0] VEC [8] = '{
    {1'b0, 1'b1, 6'd5,  24'hA5A5A5},
    {1'b1, 1'b0, 6'd5,  24'hA5A5A5},
    {1'b1, 1'b1, 6'd63, 24'h123456},
    {1'b0, 1'b0, 6'd63, 24'h123456},
    {1'b0, 1'b1, 6'd10, 24'hFFFFFF},
    {1'b0, 1'b0, 6'd10, 24'hFFFFFF},
    {1'b1, 1'b1, 6'd10, 24'h000001},
    {1'b0, 1'b0, 6'd10, 24'h000001}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit ena, input bit enb, input logic [31:0] fa,
                      input logic [31:0] fb, input int n,
                      output logic [31:0] ca, output logic [31:0] cb);
    ca = '0; cb = '0;
    a_sel = ena; b_sel = enb;
    wait_clk(HALF);
    for (int k = 0; k < n; k++) begin
      a_mosi = (k < 32) ? fa[31-k] : 1'b0;
      b_mosi = (k < 32) ? fb[31-k] : 1'b0;
      wait_clk(HALF);
      if (k < 32) begin
        ca[31-k] = a_miso;
        cb[31-k] = b_miso;
      end
      a_sclk = ena; b_sclk = enb;
      wait_clk(HALF);
      a_sclk = 1'b0; b_sclk = 1'b0;
    end
    wait_clk(HALF);
    a_sel = 1'b0; b_sel = 1'b0; a_mosi = 1'b0; b_mosi = 1'b0;
    wait_clk(2*HALF);
  endtask

  task automatic wr(input bit port, input logic [5:0] idx, input logic [23:0] d,
                    output logic [31:0] cap);
    logic [31:0] f, ca, cb;
    f = {1'b1, idx, 1'b0, d};
    xfer(!port, port, f, f, 32, ca, cb);
    cap = port ? cb : ca;
  endtask

  task automatic rd(input bit port, input logic [5:0] idx, output logic [31:0] cap);
    logic [31:0] f, ca, cb;
    f = {1'b0, idx, 1'b0, 24'h0};
    xfer(!port, port, f, f, 32, ca, cb);
    cap = port ? cb : ca;
  endtask

  initial begin
    logic [31:0] cap, ca, cb;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);

    // R1: reset state
    check("R1 miso", {30'b0, a_miso, b_miso}, 32'h0);
    check("R1 irq",  {30'b0, a_irq,  b_irq},  32'h0);
    rd(0, 6'd0, cap); check("R1 status", cap, 32'h0);
    rd(1, 6'd1, cap); check("R1 maskA",  cap, 32'h0);
    rd(0, 6'd2, cap); check("R1 maskB",  cap, 32'h0);

    // R2 R5: vector table
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][30]) wr(VEC[i][31], VEC[i][29:24], VEC[i][23:0], cap);
      else begin
        rd(VEC[i][31], VEC[i][29:24], cap);
        check("R2/R5 read", cap, {8'h0, VEC[i][23:0]});
      end
    end

    // R3: header quiet and write frame quiet
    wr(0, 6'd20, 24'h0F0F0F, cap);
    check("R3 write frame miso", cap, 32'h0);
    rd(1, 6'd20, cap);
    check("R3 header low", {24'h0, cap[31:24]}, 32'h0);
    check("R3 data MSB first", {8'h0, cap[23:0]}, 32'h000F0F0F);

    // R4: short and long frames discarded
    xfer(1, 0, {1'b1, 6'd20, 1'b0, 24'h777777}, 32'h0, 31, ca, cb);
    rd(0, 6'd20, cap); check("R4 short frame", cap, 32'h000F0F0F);
    xfer(1, 0, {1'b1, 6'd20, 1'b0, 24'h555555}, 32'h0, 33, ca, cb);
    rd(0, 6'd20, cap); check("R4 long frame", cap, 32'h000F0F0F);

    // R6: lockstep commits
    xfer(1, 1, {1'b1, 6'd30, 1'b0, 24'h111111}, {1'b1, 6'd30, 1'b0, 24'h222222}, 32, ca, cb);
    rd(1, 6'd30, cap); check("R6 same index first wins", cap, 32'h00111111);
    xfer(1, 1, {1'b1, 6'd31, 1'b0, 24'hAAAAAA}, {1'b1, 6'd32, 1'b0, 24'hBBBBBB}, 32, ca, cb);
    rd(0, 6'd31, cap); check("R6 first port index", cap, 32'h00AAAAAA);
    rd(0, 6'd32, cap); check("R6 second port index", cap, 32'h00BBBBBB);

    // R7: event set and write-one-to-clear
    evt_set = 24'h00000F; wait_clk(1); evt_set = '0; wait_clk(2);
    rd(1, 6'd0, cap); check("R7 event set", cap, 32'h0000000F);
    wr(1, 6'd0, 24'h000005, cap);
    rd(0, 6'd0, cap); check("R7 w1c", cap, 32'h0000000A);

    // R8: masked interrupts
    wr(0, 6'd1, 24'h000002, cap);
    wr(1, 6'd2, 24'h000004, cap);
    check("R8 irqA set",   {31'b0, a_irq}, 32'h1);
    check("R8 irqB clear", {31'b0, b_irq}, 32'h0);
    evt_set = 24'h000004; wait_clk(1); evt_set = '0; wait_clk(3);
    check("R8 irqB set", {31'b0, b_irq}, 32'h1);
    wr(0, 6'd0, 24'h000006, cap);
    check("R8 both clear", {30'b0, a_irq, b_irq}, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule